// File: doc/BRIEF.md
# Instruction Fetch Accelerator Cache

This block is a small direct-mapped instruction cache that sits between a 32-bit processor fetch port and a 64-bit burst-capable memory bus. When a cacheable fetch hits, the instruction word comes straight from line storage one cycle after the request is accepted, and no memory wait states are paid. When it misses, the block fetches the whole 256-bit line with a wrapping burst of four 64-bit beats. The burst starts at the beat that holds the requested word, and that word goes to the processor as soon as its beat arrives. A one-line staging buffer collects the beats, and the completed line is written into storage with the last beat.

Fetches marked non-cacheable take a bypass path: a single 32-bit-aligned bus read whose data is returned and never allocated. A snoop input reports writes that land in cacheable memory. A snooped address that falls inside a valid cached line clears that line's valid bit; the data is never updated. A global invalidate input clears every line in one cycle. Only one fetch is outstanding at a time: the fetch port accepts a request only while the block is idle.

Top module: `ifa_cache`

## Requirements
- R1: After reset every line is invalid, `fetch_ready` is 1, and `fetch_rvalid` and `mem_req` are 0. The first cacheable fetch to any address therefore misses.
- R2: A cacheable miss raises `mem_req` in the cycle after acceptance, with `mem_wrap`=1 and `mem_addr` equal to the fetch address with bits [2:0] cleared. Address and `mem_wrap` hold steady until the cycle in which `mem_gnt` is 1.
- R3: On a miss, `fetch_rvalid` pulses exactly once, in the cycle after the first beat. Its data is bits [63:32] of that beat when fetch address bit 2 is 1, and bits [31:0] otherwise.
- R4: The k-th beat (k=0..3) of a refill is stored as 64-bit word ((addr[4:3]+k) mod 4) of the line. Once the fourth beat has arrived, a fetch of any 32-bit word of that line hits and returns that word.
- R5: A cacheable fetch that hits returns its word with `fetch_rvalid`=1 in the cycle after acceptance and raises no bus request.
- R6: A non-cacheable fetch issues one request with `mem_wrap`=0 and `mem_addr` equal to the fetch address with bits [1:0] cleared. It expects a single beat and returns the 32-bit half chosen by address bit 2. It allocates nothing, so a later cacheable fetch to the same address misses.
- R7: A snoop whose address falls in a valid cached line invalidates that line, so the next fetch to it misses. A snoop with the same index but a different tag has no effect.
- R8: A snoop that matches the line being refilled, arriving while the refill is in progress, leaves that line invalid once the refill completes.
- R9: `inval_all` clears every valid bit in one cycle. When it is raised during a refill, that refill leaves its line invalid.
- R10: The cache is direct-mapped on address bits [10:5], with tag bits [31:11]. A refill of one tag evicts the other tag held at the same index.
- R11: `fetch_ready` is 0 from the acceptance of a miss or bypass fetch until its last beat has been taken, and `mem_req` is never 1 while `fetch_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_all | input | 1 | Invalidate all lines |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_cacheable | input | 1 | 1 = cacheable, 0 = bypass |
| fetch_ready | output | 1 | Block idle, request will be accepted |
| fetch_rvalid | output | 1 | Fetch data valid pulse |
| fetch_rdata | output | 32 | Fetched instruction word |
| mem_req | output | 1 | Bus request |
| mem_addr | output | 32 | Bus start address |
| mem_wrap | output | 1 | 1 = four-beat wrapping burst, 0 = single read |
| mem_gnt | input | 1 | Bus accepts the request |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 64 | Read beat data |
| snoop_valid | input | 1 | Observed write to cacheable memory |
| snoop_addr | input | 32 | Address of the observed write |

## Verification
The hardest cases to reach are the races between a refill and an invalidation: a snoop or a global invalidate that lands in the middle of a burst, after the line has been chosen but before its valid bit is set. The bench plays the memory bus itself, beat by beat, so it can inject a snoop on the filling line alongside the third beat, or a global invalidate alongside the second beat. It then refetches and expects a fresh bus request. Because the bus model returns address-derived data, every forwarded word and every later hit also shows whether the wrap order placed each beat in the right slot.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
    localparam int ADDR_W  = 32;
    localparam int FETCH_W = 32;
    localparam int BUS_W   = 64;
    localparam int BEATS   = 4;
    localparam int LINES   = 64;
    localparam int LINE_W  = BUS_W * BEATS;
    localparam int OFF_W   = $clog2(LINE_W / 8);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int BEAT_W  = $clog2(BEATS);
    localparam int HALF_W  = $clog2(BUS_W / FETCH_W);
    localparam int BYTE_W  = $clog2(FETCH_W / 8);

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_FILL, ST_BYP} ctl_state_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [BEAT_W-1:0] beat;
        logic [HALF_W-1:0] half;
        logic [BYTE_W-1:0] byte_off;
    } fa_t;

    function automatic logic [FETCH_W-1:0] pick_half(input logic [BUS_W-1:0] w,
                                                     input logic [HALF_W-1:0] h);
        return w[int'(h)*FETCH_W +: FETCH_W];
    endfunction

    function automatic logic [FETCH_W-1:0] line_word(input logic [LINE_W-1:0] ln,
                                                     input logic [BEAT_W-1:0] b,
                                                     input logic [HALF_W-1:0] h);
        return ln[(int'(b)*(BUS_W/FETCH_W) + int'(h))*FETCH_W +: FETCH_W];
    endfunction
endpackage

// File: rtl/ifa_tag_store.sv
module ifa_tag_store #(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int TAG_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit,
    input  logic             snp_valid,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_keep,
    output logic [DEPTH-1:0] valid_vec
);
    logic [TAG_W-1:0] tags [DEPTH];
    logic             snp_hit;

    assign look_hit = valid_vec[look_idx] && (tags[look_idx] == look_tag);
    assign snp_hit  = snp_valid && valid_vec[snp_idx] && (tags[snp_idx] == snp_tag)
                      && !(fill_we && (fill_idx == snp_idx));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_vec <= '0;
        end else begin
            if (fill_we) valid_vec[fill_idx] <= fill_keep;
            if (snp_hit) valid_vec[snp_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) tags[fill_idx] <= fill_tag;
    end
endmodule

// File: rtl/ifa_data_store.sv
module ifa_data_store #(
    parameter int DEPTH  = 64,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [LINE_W-1:0] wline,
    input  logic [IDX_W-1:0]  ridx,
    output logic [LINE_W-1:0] rline
);
    logic [LINE_W-1:0] mem [DEPTH];

    assign rline = mem[ridx];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wline;
    end
endmodule

// File: rtl/ifa_refill_buf.sv
module ifa_refill_buf #(
    parameter int BUS_W  = 64,
    parameter int BEATS  = 4,
    parameter int BEAT_W = $clog2(BEATS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [BEAT_W-1:0]      start_beat,
    input  logic                   beat_valid,
    input  logic [BUS_W-1:0]       beat_data,
    output logic                   first,
    output logic                   last,
    output logic [BUS_W*BEATS-1:0] line_out
);
    logic [BEAT_W-1:0] base_q, cnt_q, cur_slot;
    logic [BUS_W-1:0]  slot_q [BEATS];

    assign cur_slot = base_q + cnt_q;
    assign first    = (cnt_q == '0);
    assign last     = (cnt_q == BEAT_W'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            base_q <= start_beat;
            cnt_q  <= '0;
        end else if (beat_valid) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar s = 0; s < BEATS; s++) begin : g_slot
        logic take;
        assign take = beat_valid && (cur_slot == BEAT_W'(s));
        assign line_out[s*BUS_W +: BUS_W] = take ? beat_data : slot_q[s];
        always_ff @(posedge clk) begin
            if (take) slot_q[s] <= beat_data;
        end
    end
endmodule

// File: rtl/ifa_cache.sv
module ifa_cache
    import ifa_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               inval_all,
    input  logic               fetch_req,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic               fetch_cacheable,
    output logic               fetch_ready,
    output logic               fetch_rvalid,
    output logic [FETCH_W-1:0] fetch_rdata,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_wrap,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [BUS_W-1:0]   mem_rdata,
    input  logic               snoop_valid,
    input  logic [ADDR_W-1:0]  snoop_addr
);
    ctl_state_e        state_q;
    fa_t               cur_a, req_a, snp_a;
    logic              req_cach_q, kill_q;
    logic              look_hit, accept, beat_in, fill_done, snp_match;
    logic              fill_first, fill_last, fill_keep;
    logic [LINES-1:0]  valid_vec;
    logic [LINE_W-1:0] rd_line, fill_line;

    assign cur_a = fa_t'(fetch_addr);
    assign snp_a = fa_t'(snoop_addr);

    assign fetch_ready = (state_q == ST_IDLE);
    assign accept      = fetch_req && fetch_ready;
    assign mem_req     = (state_q == ST_REQ);
    assign mem_wrap    = req_cach_q;
    assign mem_addr    = req_cach_q ? {req_a.tag, req_a.idx, req_a.beat, {(HALF_W+BYTE_W){1'b0}}}
                                    : {req_a.tag, req_a.idx, req_a.beat, req_a.half, {BYTE_W{1'b0}}};
    assign beat_in     = (state_q == ST_FILL) && mem_rvalid;
    assign fill_done   = beat_in && fill_last;
    assign snp_match   = snoop_valid && (snp_a.tag == req_a.tag) && (snp_a.idx == req_a.idx);
    assign fill_keep   = !(kill_q || snp_match);

    ifa_tag_store #(.DEPTH(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .flush(inval_all),
        .look_idx(cur_a.idx), .look_tag(cur_a.tag), .look_hit(look_hit),
        .snp_valid(snoop_valid), .snp_idx(snp_a.idx), .snp_tag(snp_a.tag),
        .fill_we(fill_done), .fill_idx(req_a.idx), .fill_tag(req_a.tag),
        .fill_keep(fill_keep), .valid_vec(valid_vec)
    );

    ifa_data_store #(.DEPTH(LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_data (
        .clk(clk), .we(fill_done), .widx(req_a.idx), .wline(fill_line),
        .ridx(cur_a.idx), .rline(rd_line)
    );

    ifa_refill_buf #(.BUS_W(BUS_W), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_buf (
        .clk(clk), .rst(rst),
        .start((state_q == ST_REQ) && mem_gnt), .start_beat(req_a.beat),
        .beat_valid(beat_in), .beat_data(mem_rdata),
        .first(fill_first), .last(fill_last), .line_out(fill_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            req_a        <= '0;
            req_cach_q   <= 1'b0;
            kill_q       <= 1'b0;
            fetch_rvalid <= 1'b0;
            fetch_rdata  <= '0;
        end else begin
            fetch_rvalid <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    req_a      <= cur_a;
                    req_cach_q <= fetch_cacheable;
                    kill_q     <= 1'b0;
                    if (fetch_cacheable && look_hit) begin
                        fetch_rvalid <= 1'b1;
                        fetch_rdata  <= line_word(rd_line, cur_a.beat, cur_a.half);
                    end else begin
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: if (mem_gnt) state_q <= req_cach_q ? ST_FILL : ST_BYP;
                ST_FILL: begin
                    if (mem_rvalid && fill_first) begin
                        fetch_rvalid <= 1'b1;
                        fetch_rdata  <= pick_half(mem_rdata, req_a.half);
                    end
                    if (fill_done) state_q <= ST_IDLE;
                end
                default: if (mem_rvalid) begin
                    fetch_rvalid <= 1'b1;
                    fetch_rdata  <= pick_half(mem_rdata, req_a.half);
                    state_q      <= ST_IDLE;
                end
            endcase
            if ((state_q == ST_REQ || state_q == ST_FILL) && (inval_all || snp_match))
                kill_q <= 1'b1;
        end
    end
endmodule

// File: rtl/ifa_cache_chk.sv
module ifa_cache_chk #(
    parameter int LINES = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             inval_all,
    input logic             fetch_req,
    input logic             fetch_ready,
    input logic             fetch_cacheable,
    input logic             fetch_rvalid,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic             mem_wrap,
    input logic [31:0]      mem_addr,
    input logic             look_hit,
    input logic [LINES-1:0] valid_vec
);
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !fetch_ready); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wrap)); // R2

    AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_wrap |-> mem_addr[2:0] == 3'b000); // R2

    AST_BYPASS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_wrap |-> mem_addr[1:0] == 2'b00); // R6

    AST_BYPASS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fetch_req && fetch_ready && !fetch_cacheable |=> mem_req && !mem_wrap); // R6

    AST_HIT_SERVED: assert property (@(posedge clk) disable iff (rst)
        fetch_req && fetch_ready && fetch_cacheable && look_hit |=> fetch_rvalid && !mem_req); // R5

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> valid_vec == '0); // R9
endmodule

bind ifa_cache ifa_cache_chk #(.LINES(ifa_pkg::LINES)) u_chk (
    .clk(clk), .rst(rst), .inval_all(inval_all),
    .fetch_req(fetch_req), .fetch_ready(fetch_ready),
    .fetch_cacheable(fetch_cacheable), .fetch_rvalid(fetch_rvalid),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_wrap(mem_wrap), .mem_addr(mem_addr),
    .look_hit(look_hit), .valid_vec(valid_vec)
);

// File: tb/test_ifa_cache.sv
module test_ifa_cache;
    localparam logic [31:0] KEY = 32'h5A3C_96E1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inval_all = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_cacheable = 1'b0;
    logic        fetch_ready, fetch_rvalid, mem_req, mem_wrap;
    logic [31:0] fetch_rdata, mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    ifa_cache i_ifa_cache (
        .clk(clk), .rst(rst), .inval_all(inval_all),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_cacheable(fetch_cacheable),
        .fetch_ready(fetch_ready), .fetch_rvalid(fetch_rvalid), .fetch_rdata(fetch_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wrap(mem_wrap), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // One fetch; when a bus access is expected the bench acts as the memory.
    task automatic do_fetch(input logic [31:0] a, input bit cach, input bit exp_miss,
                            input int ev_beat, input bit ev_snoop, input logic [31:0] ev_addr,
                            input string rq);
        logic [31:0] exp_d, wa, exp_ma;
        logic [1:0]  sl;
        int          pulses, nb;
        exp_d = {a[31:2], 2'b00} ^ KEY;
        chk(fetch_ready, rq, "ready before fetch", {63'd0, fetch_ready}, 64'd1);
        fetch_req = 1'b1; fetch_addr = a; fetch_cacheable = cach;
        @(negedge clk);
        fetch_req = 1'b0;
        if (!exp_miss) begin
            chk(fetch_rvalid && fetch_rdata == exp_d && !mem_req, rq, "hit data",
                {mem_req, fetch_rvalid, 30'd0, fetch_rdata}, {2'b01, 30'd0, exp_d});
            @(negedge clk);
        end else begin
            exp_ma = cach ? {a[31:3], 3'b000} : {a[31:2], 2'b00};
            chk(mem_req && mem_wrap == cach && mem_addr == exp_ma, rq, "bus request",
                {mem_req, mem_wrap, 30'd0, mem_addr}, {1'b1, cach, 30'd0, exp_ma});
            chk(!fetch_ready && !fetch_rvalid, "R11", "busy after accept",
                {fetch_ready, fetch_rvalid}, 64'd0);
            @(negedge clk);
            chk(mem_req && mem_addr == exp_ma, "R2", "request held", {mem_req, mem_addr},
                {1'b1, exp_ma});
            mem_gnt = 1'b1;
            @(negedge clk);
            mem_gnt = 1'b0;
            chk(!mem_req, "R2", "request dropped after grant", {63'd0, mem_req}, 64'd0);
            pulses = 0;
            nb = cach ? 4 : 1;
            for (int k = 0; k < nb; k++) begin
                sl = a[4:3] + 2'(k);
                wa = cach ? {a[31:5], sl, 3'b000} : {a[31:3], 3'b000};
                mem_rvalid = 1'b1;
                mem_rdata  = {(wa + 32'd4) ^ KEY, wa ^ KEY};
                if (k == ev_beat) begin
                    if (ev_snoop) begin snoop_valid = 1'b1; snoop_addr = ev_addr; end
                    else inval_all = 1'b1;
                end
                @(negedge clk);
                mem_rvalid = 1'b0; snoop_valid = 1'b0; inval_all = 1'b0;
                if (k < nb - 1)
                    chk(!fetch_ready, "R11", "busy during fill", {63'd0, fetch_ready}, 64'd0);
                if (fetch_rvalid) begin
                    pulses++;
                    chk(k == 0 && fetch_rdata == exp_d, "R3", "forwarded word",
                        {k[31:0], fetch_rdata}, {32'd0, exp_d});
                end
            end
            chk(pulses == 1, "R3", "one response pulse", pulses, 1);
            chk(fetch_ready, "R11", "ready after last beat", {63'd0, fetch_ready}, 64'd1);
        end
    endtask

    task automatic pulse_snoop(input logic [31:0] a);
        snoop_valid = 1'b1; snoop_addr = a;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
    endtask

    task automatic t_reset();
        chk(fetch_ready && !fetch_rvalid && !mem_req, "R1", "reset outputs",
            {fetch_ready, fetch_rvalid, mem_req}, 64'b100);
        do_fetch(32'h0000_0A40, 1, 1, -1, 0, 0, "R1");
    endtask

    task automatic t_wrap_fill();
        do_fetch(32'h0000_1018, 1, 1, -1, 0, 0, "R2");
        do_fetch(32'h0000_1000, 1, 0, -1, 0, 0, "R4");
        do_fetch(32'h0000_1004, 1, 0, -1, 0, 0, "R4");
        do_fetch(32'h0000_100C, 1, 0, -1, 0, 0, "R4");
        do_fetch(32'h0000_1014, 1, 0, -1, 0, 0, "R4");
        do_fetch(32'h0000_101C, 1, 0, -1, 0, 0, "R5");
        do_fetch(32'h0000_2044, 1, 1, -1, 0, 0, "R3");
        do_fetch(32'h0000_2058, 1, 0, -1, 0, 0, "R4");
    endtask

    task automatic t_bypass();
        do_fetch(32'h0000_3004, 0, 1, -1, 0, 0, "R6");
        do_fetch(32'h0000_3010, 0, 1, -1, 0, 0, "R6");
        do_fetch(32'h0000_3004, 1, 1, -1, 0, 0, "R6");
    endtask

    task automatic t_snoop();
        do_fetch(32'h0000_4000, 1, 1, -1, 0, 0, "R7");
        pulse_snoop(32'h0000_5010);
        do_fetch(32'h0000_4008, 1, 0, -1, 0, 0, "R7");
        pulse_snoop(32'h0000_4014);
        do_fetch(32'h0000_4000, 1, 1, -1, 0, 0, "R7");
    endtask

    task automatic t_snoop_fill();
        do_fetch(32'h0000_6000, 1, 1, 2, 1, 32'h0000_6010, "R8");
        do_fetch(32'h0000_6000, 1, 1, -1, 0, 0, "R8");
        do_fetch(32'h0000_6004, 1, 0, -1, 0, 0, "R8");
    endtask

    task automatic t_flush();
        do_fetch(32'h0000_7000, 1, 1, -1, 0, 0, "R9");
        do_fetch(32'h0000_7020, 1, 1, -1, 0, 0, "R9");
        pulse_flush();
        do_fetch(32'h0000_7000, 1, 1, -1, 0, 0, "R9");
        do_fetch(32'h0000_7020, 1, 1, -1, 0, 0, "R9");
        do_fetch(32'h0000_8000, 1, 1, 1, 0, 0, "R9");
        do_fetch(32'h0000_8000, 1, 1, -1, 0, 0, "R9");
    endtask

    task automatic t_conflict();
        do_fetch(32'h0000_9000, 1, 1, -1, 0, 0, "R10");
        do_fetch(32'h0000_9800, 1, 1, -1, 0, 0, "R10");
        do_fetch(32'h0000_9000, 1, 1, -1, 0, 0, "R10");
        do_fetch(32'h0000_9004, 1, 0, -1, 0, 0, "R10");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wrap_fill();
        t_bypass();
        t_snoop();
        t_snoop_fill();
        t_flush();
        t_conflict();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog act=timeout exp=completion");
        summary();
        $finish;
    end
endmodule